// File: doc/BRIEF.md
# Guarded Command Selection Unit

This clocked controller carries out one guarded-command construct: a selection or a loop over a bank of N guard inputs. A start pulse arms it. The unit then samples the guards and launches the action tied to a true guard by raising that action's bit on a one-hot `go_o` vector. It holds that bit until the matching `act_done_i` bit comes back. Two inputs choose how a winner is picked. In strict (deterministic) mode, at most one guard may be true when the guards are sampled. In relaxed (non-deterministic) mode, several guards may be true at once, and one of them is granted, either by lowest index or in round-robin order.

In one-shot selection the unit waits, for as long as needed, until some guard is true. It runs one action, then pulses `done_o` and goes back to idle. A selection whose action completes at once therefore works as a plain wait for a guard. In repetition mode the guards are sampled again after every action. The loop exits with a `done_o` pulse on the first sample in which every guard is false, so a loop whose guard is always true never finishes.

A broken exclusion promise in strict mode sets a sticky error flag and drops the unit back to idle without launching anything. The flag stays set until software-independent logic drives a synchronous clear.

Top module: `gcmd_select_unit`

## Requirements
- R1: After reset, `go_o` is all zero, `done_o` is 0, `err_o` is 0, and the unit is idle. The round-robin pointer starts at index 0.
- R2: In strict mode (`nondet_i`=0), the guards are sampled on the first clock edge after the edge that takes `start_i`. If exactly one guard i is true, `go_o` equals the one-hot value with only bit i set, from the edge of that sample onward.
- R3: In strict mode, if two or more guards are true when sampled, `err_o` goes to 1 at that edge, `go_o` stays zero, `done_o` is not pulsed, and the unit returns to idle.
- R4: In relaxed mode (`nondet_i`=1) with `fair_i`=0, when several guards are true in the same sample, the guard with the lowest index is granted.
- R5: In relaxed mode with `fair_i`=1, the search starts at the pointer index and wraps past N-1 to 0. After each grant to index i, the pointer becomes i+1 modulo N. The pointer changes only on such grants.
- R6: While an action runs, the `go_o` bit is held, and guard changes are ignored, until the `act_done_i` bit of the running action is 1 at a clock edge. At that edge `go_o` returns to zero.
- R7: In selection mode (`repeat_i`=0), `done_o` is 1 for exactly one cycle, starting at the edge that sees the running action's done bit. While no guard is true, the unit keeps waiting, with no `go_o` and no `done_o`.
- R8: In repetition mode (`repeat_i`=1), the guards are sampled again on the edge after an action completes. The first sample with every guard false ends the loop with a one-cycle `done_o` pulse, including when that is the very first sample.
- R9: In repetition mode, a guard held true keeps relaunching its action, and `done_o` never goes to 1.
- R10: `err_o` stays 1 until `err_clr_i` is 1 at a clock edge. If a new collision is detected at the same edge as a clear, the flag stays set.
- R11: An action whose done bit is already 1 holds `go_o` for exactly one cycle.
- R12: In relaxed mode, a guard granted at an earlier sample keeps its grant even when a lower-index guard becomes true later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arms the construct when idle |
| nondet_i | input | 1 | 1 = relaxed selection, 0 = strict selection |
| repeat_i | input | 1 | 1 = loop until all guards false, 0 = one-shot |
| fair_i | input | 1 | 1 = round-robin tie-break in relaxed mode |
| err_clr_i | input | 1 | Synchronous clear of the error flag |
| guard_i | input | N_GUARDS | Guard conditions |
| act_done_i | input | N_GUARDS | Per-action completion |
| go_o | output | N_GUARDS | One-hot action launch, held until completion |
| done_o | output | 1 | One-cycle pulse when the construct finishes |
| err_o | output | 1 | Sticky exclusion-violation flag |

## Verification
The properties assume the mode inputs stay constant while the unit is busy. They also assume that an action's done bit is meaningful only while its `go_o` bit is high, and that `act_done_i` is released one cycle after it is honoured. The stimulus keeps to these rules: modes are changed only while the unit is idle, and each done bit is pulsed for a single edge, except in the deliberate tied-high cases, where the same action relaunches and the done bit is honoured again. The guard sweeps cover every non-zero pattern of a four-guard setup. Guards are also changed while an action runs, to show that they are ignored.

// File: rtl/gcsu_pkg.sv
package gcsu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_RUN    = 2'd2
    } gcsu_state_e;
endpackage

// File: rtl/gcsu_guard_eval.sv
module gcsu_guard_eval #(
    parameter int N_GUARDS = 4
) (
    input  logic [N_GUARDS-1:0] guard_i,
    input  logic [N_GUARDS-1:0] go_i,
    input  logic [N_GUARDS-1:0] act_done_i,
    output logic                any_o,
    output logic                multi_o,
    output logic                hit_o
);
    localparam int CW = $clog2(N_GUARDS + 1);

    logic [CW-1:0] count;

    // population count of the true guards
    always_comb begin
        count = '0;
        for (int k = 0; k < N_GUARDS; k++) begin
            count = count + CW'(guard_i[k]);
        end
    end

    assign any_o   = (count != '0);
    assign multi_o = (count > CW'(1));
    assign hit_o   = |(go_i & act_done_i);
endmodule

// File: rtl/gcsu_arbiter.sv
module gcsu_arbiter #(
    parameter int N_GUARDS = 4,
    parameter int PW       = $clog2(N_GUARDS)
) (
    input  logic [N_GUARDS-1:0] req_i,
    input  logic [PW-1:0]       ptr_i,
    input  logic                fair_i,
    output logic [N_GUARDS-1:0] grant_o,
    output logic [PW-1:0]       idx_o,
    output logic [PW-1:0]       next_ptr_o
);
    always_comb begin
        int  pos;
        logic found;
        grant_o = '0;
        idx_o   = '0;
        found   = 1'b0;
        for (int k = 0; k < N_GUARDS; k++) begin
            pos = fair_i ? (int'(ptr_i) + k) : k;
            if (pos >= N_GUARDS) begin
                pos = pos - N_GUARDS;
            end
            if (!found && req_i[pos]) begin
                found        = 1'b1;
                grant_o[pos] = 1'b1;
                idx_o        = PW'(pos);
            end
        end
        if (int'(idx_o) == N_GUARDS - 1) begin
            next_ptr_o = '0;
        end else begin
            next_ptr_o = idx_o + PW'(1);
        end
    end
endmodule

// File: rtl/gcmd_select_unit.sv
module gcmd_select_unit
    import gcsu_pkg::*;
#(
    parameter int N_GUARDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                nondet_i,
    input  logic                repeat_i,
    input  logic                fair_i,
    input  logic                err_clr_i,
    input  logic [N_GUARDS-1:0] guard_i,
    input  logic [N_GUARDS-1:0] act_done_i,
    output logic [N_GUARDS-1:0] go_o,
    output logic                done_o,
    output logic                err_o
);
    localparam int PW = $clog2(N_GUARDS);

    typedef struct packed {
        gcsu_state_e         state;
        logic [N_GUARDS-1:0] go;
        logic [PW-1:0]       ptr;
        logic                done;
        logic                err;
    } regs_t;

    regs_t r_d, r_q;

    logic                any_true;
    logic                many_true;
    logic                act_hit;
    logic [N_GUARDS-1:0] grant;
    logic [PW-1:0]       grant_idx;
    logic [PW-1:0]       ptr_next;

    gcsu_guard_eval #(.N_GUARDS(N_GUARDS)) u_eval (
        .guard_i    (guard_i),
        .go_i       (r_q.go),
        .act_done_i (act_done_i),
        .any_o      (any_true),
        .multi_o    (many_true),
        .hit_o      (act_hit)
    );

    gcsu_arbiter #(.N_GUARDS(N_GUARDS), .PW(PW)) u_arb (
        .req_i      (guard_i),
        .ptr_i      (r_q.ptr),
        .fair_i     (fair_i),
        .grant_o    (grant),
        .idx_o      (grant_idx),
        .next_ptr_o (ptr_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (err_clr_i) begin
            r_d.err = 1'b0;
        end
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (!any_true) begin
                    if (repeat_i) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end else if (!nondet_i && many_true) begin
                    r_d.err   = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.go    = grant;
                    r_d.state = ST_RUN;
                    if (nondet_i && fair_i) begin
                        r_d.ptr = ptr_next;
                    end
                end
            end
            ST_RUN: begin
                if (act_hit) begin
                    r_d.go = '0;
                    if (repeat_i) begin
                        r_d.state = ST_SAMPLE;
                    end else begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.go    = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.go    <= '0;
            r_q.ptr   <= '0;
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign go_o   = r_q.go;
    assign done_o = r_q.done;
    assign err_o  = r_q.err;

    logic unused_idx;
    assign unused_idx = ^grant_idx;
endmodule

// File: rtl/gcsu_checker.sv
module gcsu_checker
    import gcsu_pkg::*;
#(
    parameter int N_GUARDS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                nondet_i,
    input logic                fair_i,
    input logic                err_clr_i,
    input logic [N_GUARDS-1:0] guard_i,
    input logic [N_GUARDS-1:0] act_done_i,
    input logic [N_GUARDS-1:0] go_o,
    input logic                done_o,
    input logic                err_o,
    input gcsu_state_e         state_i
);
    assert_go_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_o));

    assert_go_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|go_o) && !(|(go_o & act_done_i))) |=> (go_o == $past(go_o)));

    assert_collision_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SAMPLE && !nondet_i && $countones(guard_i) > 1)
        |=> (err_o && go_o == '0 && !done_o));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (go_o == '0));

    assert_lowest_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SAMPLE && nondet_i && !fair_i && (|guard_i))
        |=> (go_o == $past(guard_i & (~guard_i + 1'b1))));
endmodule

bind gcmd_select_unit gcsu_checker #(.N_GUARDS(N_GUARDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nondet_i   (nondet_i),
    .fair_i     (fair_i),
    .err_clr_i  (err_clr_i),
    .guard_i    (guard_i),
    .act_done_i (act_done_i),
    .go_o       (go_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .state_i    (r_q.state)
);

// File: tb/gcmd_select_unit_tb.sv
module gcmd_select_unit_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         nondet_i = 1'b0;
    logic         repeat_i = 1'b0;
    logic         fair_i = 1'b0;
    logic         err_clr_i = 1'b0;
    logic [N-1:0] guard_i = '0;
    logic [N-1:0] act_done_i = '0;
    logic [N-1:0] go_o;
    logic         done_o;
    logic         err_o;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    gcmd_select_unit #(.N_GUARDS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .nondet_i(nondet_i),
        .repeat_i(repeat_i), .fair_i(fair_i), .err_clr_i(err_clr_i),
        .guard_i(guard_i), .act_done_i(act_done_i), .go_o(go_o),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    // arm the unit and let the first guard sample happen
    task automatic arm_and_sample();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        step();
    endtask

    task automatic finish_action(input logic [N-1:0] which);
        act_done_i = which;
        step();
        act_done_i = '0;
    endtask

    function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
        for (int k = 0; k < N; k++) begin
            if (v[k]) return N'(1) << k;
        end
        return '0;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [2:0] ptr_m;
        logic [N-1:0] exp_g;
        step();
        do_reset();
        check("R1 go", 32'(go_o), 0);
        check("R1 done", 32'(done_o), 0);
        check("R1 err", 32'(err_o), 0);

        // strict sweep over every non-zero pattern
        nondet_i = 1'b0; repeat_i = 1'b0;
        for (int p = 1; p < 16; p++) begin
            guard_i = N'(p);
            arm_and_sample();
            if ($countones(N'(p)) == 1) begin
                check("R2 go", 32'(go_o), 32'(p));
                check("R2 err", 32'(err_o), 0);
                finish_action(N'(p));
                check("R7 done pulse", 32'(done_o), 1);
                check("R6 go drop", 32'(go_o), 0);
                step();
                check("R7 done single", 32'(done_o), 0);
            end else begin
                check("R3 err", 32'(err_o), 1);
                check("R3 go", 32'(go_o), 0);
                check("R3 done", 32'(done_o), 0);
                step();
                check("R10 sticky", 32'(err_o), 1);
                err_clr_i = 1'b1;
                step();
                err_clr_i = 1'b0;
                check("R10 cleared", 32'(err_o), 0);
            end
        end

        // selection waits while all guards false
        guard_i = '0;
        arm_and_sample();
        for (int k = 0; k < 5; k++) begin
            check("R7 wait go", 32'(go_o), 0);
            check("R7 wait done", 32'(done_o), 0);
            step();
        end
        guard_i = 4'b0100;
        step();
        check("R7 wait release", 32'(go_o), 32'h4);
        guard_i = 4'b0011;  // changes while running are ignored
        for (int k = 0; k < 3; k++) begin
            step();
            check("R6 hold", 32'(go_o), 32'h4);
        end
        finish_action(4'b0001);  // wrong done bit is not honoured
        check("R6 foreign done", 32'(go_o), 32'h4);
        finish_action(4'b0100);
        check("R6 released", 32'(go_o), 0);
        step();

        // set wins over clear
        guard_i = 4'b0011;
        arm_and_sample();
        check("R10 set", 32'(err_o), 1);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        err_clr_i = 1'b1;
        step();
        err_clr_i = 1'b0;
        check("R10 set beats clear", 32'(err_o), 1);
        err_clr_i = 1'b1;
        step();
        err_clr_i = 1'b0;
        check("R10 clear", 32'(err_o), 0);

        // relaxed lowest-index sweep
        nondet_i = 1'b1; fair_i = 1'b0;
        for (int p = 1; p < 16; p++) begin
            guard_i = N'(p);
            exp_g = lowest(N'(p));
            arm_and_sample();
            check("R4 lowest", 32'(go_o), 32'(exp_g));
            check("R4 no err", 32'(err_o), 0);
            finish_action(exp_g);
            check("R7 done", 32'(done_o), 1);
            step();
        end

        // first-come
        guard_i = '0;
        arm_and_sample();
        guard_i = 4'b1000;
        step();
        check("R12 early", 32'(go_o), 32'h8);
        guard_i = 4'b1001;
        step();
        check("R12 keep", 32'(go_o), 32'h8);
        finish_action(4'b1000);
        step();

        // round-robin sweep from a fresh reset
        do_reset();
        nondet_i = 1'b1; fair_i = 1'b1;
        ptr_m = '0;
        for (int t = 0; t < 30; t++) begin
            logic [N-1:0] pat;
            pat = (t < 6) ? 4'b1111 : N'(((t * 7) % 15) + 1);
            exp_g = '0;
            for (int k = 0; k < N; k++) begin
                int pos;
                pos = (int'(ptr_m) + k) % N;
                if (exp_g == '0 && pat[pos]) exp_g = N'(1) << pos;
            end
            for (int k = 0; k < N; k++) begin
                if (exp_g[k]) ptr_m = 3'((k + 1) % N);
            end
            guard_i = pat;
            arm_and_sample();
            check("R5 rotate", 32'(go_o), 32'(exp_g));
            finish_action(exp_g);
            step();
        end

        // repetition
        nondet_i = 1'b0; fair_i = 1'b0; repeat_i = 1'b1;
        guard_i = 4'b0010;
        arm_and_sample();
        check("R8 first", 32'(go_o), 32'h2);
        guard_i = 4'b0100;
        finish_action(4'b0010);
        check("R8 gap", 32'(go_o), 0);
        check("R8 no done", 32'(done_o), 0);
        step();
        check("R8 second", 32'(go_o), 32'h4);
        guard_i = '0;
        finish_action(4'b0100);
        check("R8 resample", 32'(done_o), 0);
        step();
        check("R8 exit", 32'(done_o), 1);
        step();
        check("R8 exit single", 32'(done_o), 0);

        guard_i = '0;
        arm_and_sample();
        check("R8 empty loop", 32'(done_o), 1);
        step();

        // infinite loop with immediate action
        guard_i = 4'b0001;
        act_done_i = '1;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 40; k++) begin
                step();
                if (done_o) seen++;
            end
            check("R9 never done", 32'(seen), 0);
        end
        repeat_i = 1'b0;  // let the selection finish it
        step(); step();
        act_done_i = '0;
        step();

        // immediate action in selection: one-cycle go
        guard_i = 4'b1000;
        act_done_i = '1;
        arm_and_sample();
        check("R11 go", 32'(go_o), 32'h8);
        step();
        check("R11 go gone", 32'(go_o), 0);
        check("R11 done", 32'(done_o), 1);
        act_done_i = '0;
        step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule